// File: doc/BRIEF.md
# Eight-Channel Output Compare Unit

The unit holds a free-running counter that all eight compare channels share. Each channel that is set to compare mode owns a compare register and a 2-bit pin action. When the counter equals the compare value, the channel sets its flag and applies the action to its own port bit. Software can also fire any set of channel actions at once with a one-cycle force strobe. A forced action never sets a flag.

The highest channel is the master. When it fires, through a match or a force, every port bit named in the override mask takes the value of the matching bit of the override data register. This happens in the same cycle in which the owning channel may also fire, and the override data bit wins. A masked compare-mode pin is driven as an output whatever its direction bit holds.

All registers sit on a simple synchronous write bus with a combinational read port. The port is 8 bits wide and has a separate output-enable vector.

Top module: `oc_bank`

## Requirements
- R1: After reset the counter reads 0. It adds one on every clock, wraps from 0xFFFF to 0, and can be read at address 7 and on `cnt_o`.
- R2: Writing address 3 with bit n set makes compare-mode channel n apply its action at the next clock edge. It does not set flag n.
- R3: Address 3 always reads as zero.
- R4: The action code of channel n is held in bits 2n+1:2n of the action register at address 2. The codes are 00 hold, 01 toggle, 10 drive low and 11 drive high. The pin changes at the clock edge that ends the match or force cycle.
- R5: Flag n (address 6) sets when channel n is in compare mode and the counter equals its compare register (address 8+n). Writing 1 to a flag bit clears it, and a set in the same cycle wins over the clear.
- R6: When channel 7 fires, each compare-mode pin whose override mask bit (address 4) is set takes the override data bit (address 5). This holds over the owning channel's action in the same cycle.
- R7: `port_oe[n]` = direction bit n (address 1) OR (mode bit n AND mask bit n). Writing the mask never changes the direction register.
- R8: A channel whose mode bit (address 0, 1 = compare) is 0 keeps its pin value, never sets its flag, and ignores the force and the override.
- R9: Reset clears every register, all pins, all enables and all flags.
- R10: The mode, direction, action, mask, data and compare registers read back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| cnt_o | output | 16 | Counter value |
| port_out | output | 8 | Port pin values |
| port_oe | output | 8 | Port output enables |
| flag_o | output | 8 | Channel flags |

## Verification
The hardest case to reach is a master event and a channel's own event landing in the same cycle on a masked pin. The stimulus produces it in two ways. The first is one force write that carries both bit 7 and the channel's bit. The second loads the channel-7 and channel-2 compare registers with the same future count and waits for the counter to get there. It also times a flag-clear write onto the exact match cycle to show that the set wins. Finally it runs the counter through its wrap so that compare value zero matches.

// File: rtl/oc_bank_pkg.sv
package oc_bank_pkg;
   typedef enum logic [1:0] {
      ACT_HOLD = 2'b00,
      ACT_TOG  = 2'b01,
      ACT_LOW  = 2'b10,
      ACT_HIGH = 2'b11
   } act_e;

   localparam int ADR_SEL  = 0;
   localparam int ADR_DIR  = 1;
   localparam int ADR_ACT  = 2;
   localparam int ADR_FRC  = 3;
   localparam int ADR_MSK  = 4;
   localparam int ADR_DAT  = 5;
   localparam int ADR_FLG  = 6;
   localparam int ADR_CNT  = 7;
   localparam int ADR_CMP0 = 8;
endpackage

// File: rtl/oc_bank_ctr.sv
module oc_bank_ctr #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic [CW-1:0] cnt
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= cnt + 1'b1;
   end

   // R1
   a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> cnt == CW'($past(cnt) + 1'b1));
endmodule

// File: rtl/oc_bank_regs.sv
module oc_bank_regs
   import oc_bank_pkg::*;
#(
   parameter int NCH = 8,
   parameter int CW  = 16,
   parameter int AW  = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we,
   input  logic [AW-1:0]            addr,
   input  logic [CW-1:0]            wdata,
   input  logic [CW-1:0]            cnt,
   input  logic [NCH-1:0]           flags,
   output logic [NCH-1:0]           sel,
   output logic [NCH-1:0]           dir,
   output logic [NCH-1:0]           msk,
   output logic [NCH-1:0]           dat,
   output logic [2*NCH-1:0]         act,
   output logic [NCH-1:0]           frc,
   output logic [NCH-1:0]           clr,
   output logic [NCH-1:0][CW-1:0]   cmp,
   output logic [CW-1:0]            rdata
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel <= '0;
         dir <= '0;
         msk <= '0;
         dat <= '0;
         act <= '0;
         cmp <= '0;
      end else if (we) begin
         case (addr)
            AW'(ADR_SEL): sel <= wdata[NCH-1:0];
            AW'(ADR_DIR): dir <= wdata[NCH-1:0];
            AW'(ADR_ACT): act <= wdata[2*NCH-1:0];
            AW'(ADR_MSK): msk <= wdata[NCH-1:0];
            AW'(ADR_DAT): dat <= wdata[NCH-1:0];
            default: begin
               for (int i = 0; i < NCH; i++)
                  if (addr == AW'(ADR_CMP0 + i)) cmp[i] <= wdata;
            end
         endcase
      end
   end

   assign frc = (we && addr == AW'(ADR_FRC)) ? wdata[NCH-1:0] : '0;
   assign clr = (we && addr == AW'(ADR_FLG)) ? wdata[NCH-1:0] : '0;

   always_comb begin
      rdata = '0;
      case (addr)
         AW'(ADR_SEL): rdata = CW'(sel);
         AW'(ADR_DIR): rdata = CW'(dir);
         AW'(ADR_ACT): rdata = CW'(act);
         AW'(ADR_MSK): rdata = CW'(msk);
         AW'(ADR_DAT): rdata = CW'(dat);
         AW'(ADR_FLG): rdata = CW'(flags);
         AW'(ADR_CNT): rdata = cnt;
         default: begin
            for (int i = 0; i < NCH; i++)
               if (addr == AW'(ADR_CMP0 + i)) rdata = cmp[i];
         end
      endcase
   end

   // R7: only a write to the direction address moves it
   a_r7_dir_untouched: assert property (@(posedge clk) disable iff (!rst_n)
      !(we && addr == AW'(ADR_DIR)) |=> $stable(dir));
   // R10: mask holds its written value
   a_r10_mask_written: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == AW'(ADR_MSK)) |=> msk == $past(wdata[NCH-1:0]));
endmodule

// File: rtl/oc_bank_chan.sv
module oc_bank_chan
   import oc_bank_pkg::*;
#(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sel,
   input  act_e          act,
   input  logic [CW-1:0] cnt,
   input  logic [CW-1:0] cmp,
   input  logic          frc,
   input  logic          clr,
   input  logic          mev,
   input  logic          msk,
   input  logic          dat,
   output logic          ev,
   output logic          pin,
   output logic          flag
);
   logic hit, ovr, pin_nx;

   assign hit = sel && (cnt == cmp);
   assign ev  = sel && (hit || frc);
   assign ovr = sel && msk && mev;

   always_comb begin
      pin_nx = pin;
      if (ovr) begin
         pin_nx = dat;
      end else if (ev) begin
         case (act)
            ACT_TOG:  pin_nx = ~pin;
            ACT_LOW:  pin_nx = 1'b0;
            ACT_HIGH: pin_nx = 1'b1;
            default:  pin_nx = pin;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin  <= 1'b0;
         flag <= 1'b0;
      end else begin
         pin  <= pin_nx;
         flag <= (flag & ~clr) | hit;
      end
   end

   // R2
   a_r2_force_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (frc && !hit && !flag) |=> !flag);
   // R4
   a_r4_toggle: assert property (@(posedge clk) disable iff (!rst_n)
      (ev && !ovr && act == ACT_TOG) |=> pin != $past(pin));
   // R5: set beats clear
   a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> flag);
   // R6
   a_r6_override: assert property (@(posedge clk) disable iff (!rst_n)
      ovr |=> pin == $past(dat));
   // R8
   a_r8_input_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !sel |=> pin == $past(pin));
endmodule

// File: rtl/oc_bank.sv
module oc_bank
   import oc_bank_pkg::*;
#(
   parameter int NCH = 8,
   parameter int CW  = 16,
   parameter int AW  = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           bus_we,
   input  logic [AW-1:0]  bus_addr,
   input  logic [CW-1:0]  bus_wdata,
   output logic [CW-1:0]  bus_rdata,
   output logic [CW-1:0]  cnt_o,
   output logic [NCH-1:0] port_out,
   output logic [NCH-1:0] port_oe,
   output logic [NCH-1:0] flag_o
);
   localparam int MST = NCH - 1;

   generate
      if (NCH < 2 || 2 * NCH > CW || AW < $clog2(ADR_CMP0 + NCH)) begin : g_bad
         $error("oc_bank: parameter set not supported");
      end
   endgenerate

   logic [NCH-1:0]         sel, dir, msk, dat, frc, clr, ev;
   logic [2*NCH-1:0]       act;
   logic [NCH-1:0][CW-1:0] cmp;
   logic [CW-1:0]          cnt;

   oc_bank_ctr #(.CW(CW)) u_ctr (.clk(clk), .rst_n(rst_n), .cnt(cnt));

   oc_bank_regs #(.NCH(NCH), .CW(CW), .AW(AW)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr),
      .wdata(bus_wdata), .cnt(cnt), .flags(flag_o),
      .sel(sel), .dir(dir), .msk(msk), .dat(dat), .act(act),
      .frc(frc), .clr(clr), .cmp(cmp), .rdata(bus_rdata)
   );

   generate
      for (genvar i = 0; i < NCH; i++) begin : g_ch
         oc_bank_chan #(.CW(CW)) u_ch (
            .clk(clk), .rst_n(rst_n), .sel(sel[i]),
            .act(act_e'(act[2*i +: 2])), .cnt(cnt), .cmp(cmp[i]),
            .frc(frc[i]), .clr(clr[i]), .mev(ev[MST]),
            .msk(msk[i]), .dat(dat[i]),
            .ev(ev[i]), .pin(port_out[i]), .flag(flag_o[i])
         );
      end
   endgenerate

   assign port_oe = dir | (sel & msk);
   assign cnt_o   = cnt;

   // R9
   a_r9_reset_quiet: assert property (@(posedge clk)
      !rst_n |-> (port_out == '0 && flag_o == '0 && port_oe == '0));
endmodule

// File: tb/oc_bank_bench.sv
module oc_bank_bench;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata, cnt_o;
   logic [7:0]  port_out, port_oe, flag_o;

   int checks = 0;
   int fails  = 0;

   oc_bank u_oc_bank (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_o(cnt_o),
      .port_out(port_out), .port_oe(port_oe), .flag_o(flag_o)
   );

   always #(CLK_P/2) clk = ~clk;

   // behavioural reference
   logic [15:0] m_cnt, m_act;
   logic [7:0]  m_sel, m_dir, m_msk, m_dat, m_flag, m_pin;
   logic [15:0] m_cmp [8];

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt = 0; m_act = 0; m_sel = 0; m_dir = 0; m_msk = 0;
         m_dat = 0; m_flag = 0; m_pin = 0;
         for (int i = 0; i < 8; i++) m_cmp[i] = 0;
      end else begin
         logic [7:0] hit, frc, clr, ev, nx;
         frc = (bus_we && bus_addr == 3) ? bus_wdata[7:0] : 8'h00;
         clr = (bus_we && bus_addr == 6) ? bus_wdata[7:0] : 8'h00;
         for (int i = 0; i < 8; i++) begin
            hit[i] = m_sel[i] && (m_cnt == m_cmp[i]);
            ev[i]  = m_sel[i] && (hit[i] || frc[i]);
         end
         for (int i = 0; i < 8; i++) begin
            nx[i] = m_pin[i];
            if (ev[7] && m_msk[i] && m_sel[i]) nx[i] = m_dat[i];
            else if (ev[i]) begin
               case (m_act[2*i +: 2])
                  2'b01: nx[i] = ~m_pin[i];
                  2'b10: nx[i] = 1'b0;
                  2'b11: nx[i] = 1'b1;
                  default: nx[i] = m_pin[i];
               endcase
            end
         end
         m_pin  = nx;
         m_flag = (m_flag & ~clr) | hit;
         if (bus_we) begin
            case (bus_addr)
               4'd0: m_sel = bus_wdata[7:0];
               4'd1: m_dir = bus_wdata[7:0];
               4'd2: m_act = bus_wdata;
               4'd4: m_msk = bus_wdata[7:0];
               4'd5: m_dat = bus_wdata[7:0];
               default: if (bus_addr >= 8) m_cmp[bus_addr - 8] = bus_wdata;
            endcase
         end
         m_cnt = m_cnt + 1;
      end
   end

   function automatic logic [15:0] m_read(input logic [3:0] a);
      case (a)
         4'd0: return {8'h00, m_sel};
         4'd1: return {8'h00, m_dir};
         4'd2: return m_act;
         4'd3: return 16'h0000;
         4'd4: return {8'h00, m_msk};
         4'd5: return {8'h00, m_dat};
         4'd6: return {8'h00, m_flag};
         4'd7: return m_cnt;
         default: return m_cmp[a - 8];
      endcase
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act_v, input logic [31:0] exp_v);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act_v, exp_v, $time);
      end
   endtask

   // per-cycle comparison against the reference
   always @(negedge clk) begin
      if (rst_n) begin
         chk(cnt_o == m_cnt, "R1 counter", cnt_o, m_cnt);
         chk(port_out == m_pin, "R4 pins", port_out, m_pin);
         chk(port_oe == (m_dir | (m_sel & m_msk)), "R7 enables", port_oe, m_dir | (m_sel & m_msk));
         chk(flag_o == m_flag, "R5 flags", flag_o, m_flag);
         chk(bus_rdata == m_read(bus_addr), "R10 readback", bus_rdata, m_read(bus_addr));
      end
   end

   task automatic wr(input logic [3:0] a, input logic [15:0] d);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_we = 1'b0;
   endtask

   task automatic wait_cnt(input logic [15:0] v);
      while (m_cnt != v) begin @(posedge clk); #1; end
   endtask

   task automatic report;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      #(CLK_P * 150000);
      chk(1'b0, "watchdog", 0, 1);
      report();
   end

   initial begin
      logic [15:0] t;
      repeat (3) @(posedge clk);
      #1;
      // R9 reset state
      chk(port_out == 8'h00, "R9 pins", port_out, 0);
      chk(port_oe == 8'h00, "R9 enables", port_oe, 0);
      chk(flag_o == 8'h00, "R9 flags", flag_o, 0);
      chk(bus_rdata == 16'h0000, "R9 mode reg", bus_rdata, 0);
      rst_n = 1'b1;
      @(posedge clk); #1;

      wr(0, 16'h0077);
      wr(1, 16'h0001);
      wr(2, 16'h7539);
      // R2 force: ch0 toggle, ch1 low, ch2 high, ch3 input
      wr(3, 16'h000F);
      chk(port_out == 8'h05, "R2 forced actions", port_out, 8'h05);
      chk(port_out[3] == 1'b0, "R8 input ignores force", port_out[3], 0);
      chk(flag_o == 8'h00, "R2 force sets no flag", flag_o, 0);
      chk(bus_rdata == 16'h0000, "R3 force reads zero", bus_rdata, 0);

      // R5 real matches on ch0 and ch4
      t = m_cnt + 16'd30;
      wr(8, t);
      wr(12, t);
      wait_cnt(t + 16'd1);
      chk(flag_o == 8'h11, "R5 match flags", flag_o, 8'h11);
      chk(port_out == 8'h14, "R4 toggle on match", port_out, 8'h14);
      wr(6, 16'h0011);
      chk(flag_o == 8'h00, "R5 write-one clear", flag_o, 0);

      // R5 clear in the match cycle loses
      t = m_cnt + 16'd20;
      wr(9, t);
      wait_cnt(t);
      wr(6, 16'h0002);
      chk(flag_o[1] == 1'b1, "R5 set wins", flag_o[1], 1);

      // R7, R10 mask/data
      wr(4, 16'h000C);
      wr(5, 16'h0008);
      chk(port_oe == 8'h05, "R7 mask enables", port_oe, 8'h05);
      bus_addr = 1; #1;
      chk(bus_rdata == 16'h0001, "R7 direction kept", bus_rdata, 1);
      bus_addr = 4; #1;
      chk(bus_rdata == 16'h000C, "R10 mask readback", bus_rdata, 16'h000C);

      // R6 override against a simultaneous force on ch2
      wr(0, 16'h00F7);
      wr(3, 16'h0084);
      chk(port_out == 8'h90, "R6 override on force", port_out, 8'h90);
      chk(port_out[3] == 1'b0, "R8 input ignores override", port_out[3], 0);
      chk(flag_o == 8'h02, "R2 no flags from force", flag_o, 8'h02);

      // R6 override against a simultaneous real match on ch2
      wr(3, 16'h0004);
      chk(port_out == 8'h94, "R4 set action", port_out, 8'h94);
      t = m_cnt + 16'd20;
      wr(10, t);
      wr(15, t);
      wait_cnt(t + 16'd1);
      chk(port_out == 8'h10, "R6 override on match", port_out, 8'h10);
      chk(flag_o == 8'h86, "R5 flags from matches", flag_o, 8'h86);

      // R1 wrap, compare value zero
      wr(13, 16'h0000);
      wait_cnt(16'h0000);
      chk(cnt_o == 16'h0000, "R1 wrap", cnt_o, 0);
      @(posedge clk); #1;
      chk(flag_o[5] == 1'b1, "R5 match at zero", flag_o[5], 1);
      repeat (4) @(posedge clk);
      #1;
      report();
   end
endmodule